// File: doc/BRIEF.md
# Microcoded Step Adder/Subtractor with Presence Checking

This block is a small datapath under horizontal microcode control. Each cycle it receives an instruction word made of three operation bits (no-op, add-step, subtract-step) and a 5-bit unsigned step parameter, together with a 22-bit data word and a flag telling whether that word is present. A controller turns the instruction into select codes for a one-to-two splitter and a two-to-one merger, and into presence flags for the step parameter. The splitter sends the data word either to an adding unit or to a subtracting unit. The merger brings the chosen result back to the registered output.

Every internal signal carries a presence flag beside its value. Each unit obeys strict rules. It fires only when all of its inputs are present and stays silent only when all of them are absent. Any mixed case is reported on a presence error output. Asking for both add and subtract in one instruction is reported on a conflict output. The result, its valid flag and both error flags are registered, so they appear one clock after the instruction is sampled.

Top module: `incdec_ucode_core`

## Requirements
- R1: While reset (`rst_n` low) is held, and after reset is released but before the first instruction, `res_data`, `res_valid`, `err_conflict` and `err_presence` are all 0.
- R2: An instruction with `op_inc`=1 and `op_dec`=0, and with `in_present`=1, gives `res_valid`=1 and `res_data` = (`in_data` + `op_step`) mod 2^22 on the next rising edge.
- R3: An instruction with `op_dec`=1 and `op_inc`=0, and with `in_present`=1, gives `res_valid`=1 and `res_data` = (`in_data` - `op_step`) mod 2^22 on the next rising edge.
- R4: The `op_nop` bit has no effect when it is set together with exactly one of `op_inc` or `op_dec`. The result equals that of the same instruction with `op_nop`=0.
- R5: When `op_inc` and `op_dec` are both 1, `err_conflict` is 1 on the next edge and `res_valid` is 0. Both selects then take the idle code, so `err_presence` follows R7.
- R6: An add or subtract instruction with `in_present`=0 raises `err_presence` on the next edge, and `res_valid` is 0.
- R7: An instruction with neither `op_inc` nor `op_dec` set uses the idle select code. If `in_present`=1 this is a presence violation, and `err_presence`=1 on the next edge. If `in_present`=0, both error flags are 0. In both cases `res_valid` is 0.
- R8: `res_data` reads 0 in every cycle where `res_valid` is 0.
- R9: The step operand is unsigned over its full range 0..31. Every output reflects only the instruction sampled at the previous edge, so back-to-back instructions produce back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 22 | Data word from the environment |
| in_present | input | 1 | Presence flag of `in_data` |
| op_nop | input | 1 | Instruction bit: no-op |
| op_inc | input | 1 | Instruction bit: add step |
| op_dec | input | 1 | Instruction bit: subtract step |
| op_step | input | 5 | Unsigned step parameter of the instruction |
| res_data | output | 22 | Registered result, 0 when not valid |
| res_valid | output | 1 | Registered result presence flag |
| err_conflict | output | 1 | Registered flag: add and subtract requested together |
| err_presence | output | 1 | Registered flag: some unit saw a partially present input set |

## Verification
The add and subtract paths are run with mid-range data, with data that wraps past 2^22 in both directions, and with the step at 0 and at 31. These cases separate correct modular arithmetic from a wrong operand width or a swapped path. The same operations are issued with and without the no-op bit to show that this bit is ignored. Error cases pair each instruction kind (add, subtract, both, neither) with present and absent data. This separates the conflict flag from the presence flag and shows that the idle select is accepted only when no data is present. A back-to-back stream of mixed instructions then checks the one-cycle alignment of the results.

// File: rtl/incdec_pkg.sv
package incdec_pkg;

    // Select code shared by splitter and merger: two routes plus idle.
    typedef enum logic [1:0] {
        ROUTE_ADD  = 2'd0,
        ROUTE_SUB  = 2'd1,
        ROUTE_IDLE = 2'd2
    } route_sel_e;

    typedef struct packed {
        route_sel_e split_sel;
        route_sel_e merge_sel;
        logic [1:0] step_present;   // bit 0: adder step, bit 1: subtractor step
        logic       conflict;
    } ctrl_word_t;

endpackage

// File: rtl/incdec_ctrl.sv
module incdec_ctrl
    import incdec_pkg::*;
(
    input  logic       op_inc,
    input  logic       op_dec,
    output ctrl_word_t ctrl
);

    always_comb begin
        ctrl.split_sel    = ROUTE_IDLE;
        ctrl.merge_sel    = ROUTE_IDLE;
        ctrl.step_present = 2'b00;
        ctrl.conflict     = op_inc && op_dec;
        if (op_inc && !op_dec) begin
            ctrl.split_sel    = ROUTE_ADD;
            ctrl.merge_sel    = ROUTE_ADD;
            ctrl.step_present = 2'b01;
        end else if (op_dec && !op_inc) begin
            ctrl.split_sel    = ROUTE_SUB;
            ctrl.merge_sel    = ROUTE_SUB;
            ctrl.step_present = 2'b10;
        end
    end

endmodule

// File: rtl/incdec_split.sv
module incdec_split
    import incdec_pkg::*;
#(
    parameter int unsigned WIDTH = 22,
    parameter int unsigned WAYS  = 2
) (
    input  logic [WIDTH-1:0] din,
    input  logic             din_p,
    input  route_sel_e       sel,
    output logic [WIDTH-1:0] dout   [WAYS],
    output logic [WAYS-1:0]  dout_p,
    output logic             viol
);

    logic sel_is_idle;
    logic sel_in_range;

    assign sel_is_idle  = (sel == ROUTE_IDLE);
    assign sel_in_range = (int'(sel) < WAYS);

    for (genvar i = 0; i < WAYS; i++) begin : g_way
        assign dout[i]   = din;
        assign dout_p[i] = din_p && (int'(sel) == i);
    end

    // Idle only with absent input; a route code only with present input.
    assign viol = (din_p && !sel_in_range) || (!din_p && !sel_is_idle);

endmodule

// File: rtl/incdec_stepper.sv
module incdec_stepper #(
    parameter int unsigned WIDTH    = 22,
    parameter int unsigned STEP_W   = 5,
    parameter bit          SUBTRACT = 1'b0
) (
    input  logic [WIDTH-1:0]  a,
    input  logic              a_p,
    input  logic [STEP_W-1:0] s,
    input  logic              s_p,
    output logic [WIDTH-1:0]  y,
    output logic              y_p,
    output logic              viol
);

    localparam int unsigned PAD_W = WIDTH - STEP_W;

    logic [WIDTH-1:0] s_ext;

    assign s_ext = {{PAD_W{1'b0}}, s};

    if (SUBTRACT) begin : g_sub
        assign y = a - s_ext;
    end else begin : g_add
        assign y = a + s_ext;
    end

    assign y_p  = a_p && s_p;
    assign viol = a_p ^ s_p;

endmodule

// File: rtl/incdec_merge.sv
module incdec_merge
    import incdec_pkg::*;
#(
    parameter int unsigned WIDTH = 22,
    parameter int unsigned WAYS  = 2
) (
    input  logic [WIDTH-1:0] din   [WAYS],
    input  logic [WAYS-1:0]  din_p,
    input  route_sel_e       sel,
    output logic [WIDTH-1:0] dout,
    output logic             dout_p,
    output logic             viol
);

    localparam int unsigned CNT_W = $clog2(WAYS + 1);

    logic [CNT_W-1:0] n_present;
    logic             sel_hit;

    always_comb begin
        n_present = '0;
        sel_hit   = 1'b0;
        dout      = '0;
        for (int i = 0; i < WAYS; i++) begin
            n_present = n_present + CNT_W'(din_p[i]);
            if (din_p[i] && int'(sel) == i) begin
                sel_hit = 1'b1;
                dout    = din[i];
            end
        end
    end

    assign dout_p = (n_present == CNT_W'(1)) && sel_hit;
    assign viol   = (n_present > CNT_W'(1))
                 || ((n_present == CNT_W'(1)) && !sel_hit)
                 || ((n_present == '0) && (sel != ROUTE_IDLE));

endmodule

// File: rtl/incdec_ucode_core.sv
module incdec_ucode_core
    import incdec_pkg::*;
#(
    parameter int unsigned DATA_W = 22,
    parameter int unsigned STEP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_present,
    input  logic              op_nop,
    input  logic              op_inc,
    input  logic              op_dec,
    input  logic [STEP_W-1:0] op_step,
    output logic [DATA_W-1:0] res_data,
    output logic              res_valid,
    output logic              err_conflict,
    output logic              err_presence
);

    localparam int unsigned WAYS = 2;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              conflict;
        logic              presence;
    } out_state_t;

    ctrl_word_t        ctrl;
    logic [DATA_W-1:0] way_in   [WAYS];
    logic [WAYS-1:0]   way_in_p;
    logic [DATA_W-1:0] way_out  [WAYS];
    logic [WAYS-1:0]   way_out_p;
    logic [WAYS-1:0]   unit_viol;
    logic              split_viol;
    logic              merge_viol;
    logic [DATA_W-1:0] merged;
    logic              merged_p;
    out_state_t        state_d;
    out_state_t        state_q;

    incdec_ctrl u_ctrl (
        .op_inc (op_inc),
        .op_dec (op_dec),
        .ctrl   (ctrl)
    );

    incdec_split #(.WIDTH(DATA_W), .WAYS(WAYS)) u_split (
        .din    (in_data),
        .din_p  (in_present),
        .sel    (ctrl.split_sel),
        .dout   (way_in),
        .dout_p (way_in_p),
        .viol   (split_viol)
    );

    for (genvar i = 0; i < WAYS; i++) begin : g_unit
        incdec_stepper #(
            .WIDTH    (DATA_W),
            .STEP_W   (STEP_W),
            .SUBTRACT (i == 1)
        ) u_stepper (
            .a    (way_in[i]),
            .a_p  (way_in_p[i]),
            .s    (op_step),
            .s_p  (ctrl.step_present[i]),
            .y    (way_out[i]),
            .y_p  (way_out_p[i]),
            .viol (unit_viol[i])
        );
    end

    incdec_merge #(.WIDTH(DATA_W), .WAYS(WAYS)) u_merge (
        .din    (way_out),
        .din_p  (way_out_p),
        .sel    (ctrl.merge_sel),
        .dout   (merged),
        .dout_p (merged_p),
        .viol   (merge_viol)
    );

    always_comb begin
        state_d          = '0;
        state_d.conflict = ctrl.conflict;
        state_d.presence = split_viol || merge_viol || (|unit_viol);
        state_d.valid    = merged_p && !state_d.conflict && !state_d.presence;
        state_d.data     = state_d.valid ? merged : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_data     = state_q.data;
    assign res_valid    = state_q.valid;
    assign err_conflict = state_q.conflict;
    assign err_presence = state_q.presence;

    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_inc && !op_dec && in_present) |=>
            (res_valid && res_data == $past(in_data + DATA_W'(op_step)))); // R2
    AST_SUB_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_dec && !op_inc && in_present) |=>
            (res_valid && res_data == $past(in_data - DATA_W'(op_step)))); // R3
    AST_CONFLICT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (op_inc && op_dec) |=> (err_conflict && !res_valid)); // R5
    AST_ABSENT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_inc ^ op_dec) && !in_present) |=> (err_presence && !res_valid)); // R6
    AST_NOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_nop && !op_inc && !op_dec) |=> (!res_valid && !err_conflict)); // R7
    AST_IDLE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_inc && !op_dec && in_present) |=> err_presence); // R7
    AST_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_data == '0)); // R8

endmodule

// File: tb/incdec_ucode_core_tb.sv
`timescale 1ns/1ps
module incdec_ucode_core_tb;

    localparam int DW = 22;
    localparam int SW = 5;
    localparam logic [DW-1:0] MASK = {DW{1'b1}};

    typedef struct {
        logic [DW-1:0] data;
        logic          valid;
        logic          conf;
        logic          pres;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_present = 1'b0;
    logic          op_nop = 1'b0;
    logic          op_inc = 1'b0;
    logic          op_dec = 1'b0;
    logic [SW-1:0] op_step = '0;
    logic [DW-1:0] res_data;
    logic          res_valid;
    logic          err_conflict;
    logic          err_presence;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    incdec_ucode_core u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_data      (in_data),
        .in_present   (in_present),
        .op_nop       (op_nop),
        .op_inc       (op_inc),
        .op_dec       (op_dec),
        .op_step      (op_step),
        .res_data     (res_data),
        .res_valid    (res_valid),
        .err_conflict (err_conflict),
        .err_presence (err_presence)
    );

    task automatic compare(input exp_t e);
        n_tests++;
        if (res_data !== e.data || res_valid !== e.valid ||
            err_conflict !== e.conf || err_presence !== e.pres) begin
            n_fail++;
            $display("FAIL %s: got data=%h valid=%b conf=%b pres=%b, expected data=%h valid=%b conf=%b pres=%b",
                     e.req, res_data, res_valid, err_conflict, err_presence,
                     e.data, e.valid, e.conf, e.pres);
        end
    endtask

    // Driver: applies one instruction and pushes the expected result.
    task automatic issue(input bit nop, input bit inc, input bit dec,
                         input int step, input logic [DW-1:0] din,
                         input bit dp, input string req);
        exp_t e;
        bit   route;
        @(negedge clk);
        op_nop     = nop;
        op_inc     = inc;
        op_dec     = dec;
        op_step    = SW'(step);
        in_data    = din;
        in_present = dp;
        route   = inc ^ dec;
        e.conf  = inc && dec;
        e.pres  = route ? !dp : dp;
        e.valid = route && dp;
        if (!e.valid)  e.data = '0;
        else if (inc)  e.data = (din + DW'(step)) & MASK;
        else           e.data = (din - DW'(step)) & MASK;
        e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: one result per instruction, one clock later.
    always @(posedge clk) begin
        #2;
        if (rst_n && sb_q.size() > 0) begin
            compare(sb_q.pop_front());
        end
    end

    initial begin
        exp_t zero;
        zero.data = '0; zero.valid = 0; zero.conf = 0; zero.pres = 0;
        zero.req = "R1 in reset";
        repeat (3) @(negedge clk);
        compare(zero);
        rst_n = 1'b1;
        @(negedge clk);
        zero.req = "R1 after release";
        compare(zero);

        issue(1, 1, 0, 6,  22'd100,     1, "R2 R4 nop+inc(6)");
        issue(1, 0, 1, 10, 22'd100,     1, "R3 R4 nop+dec(10)");
        issue(0, 1, 0, 6,  22'd100,     1, "R2 R4 inc(6) no nop");
        issue(0, 1, 0, 31, 22'h3FFFF0,  1, "R2 R9 inc(31) wrap");
        issue(0, 0, 1, 10, 22'd3,       1, "R3 dec(10) wrap");
        issue(0, 1, 0, 0,  22'd55,      1, "R9 inc(0)");
        issue(0, 0, 1, 31, 22'd31,      1, "R3 R9 dec(31) to zero");
        issue(0, 1, 1, 4,  22'd9,       1, "R5 conflict with data");
        issue(1, 1, 1, 4,  22'd9,       0, "R5 conflict no data");
        issue(0, 1, 0, 7,  22'd9,       0, "R6 inc no data");
        issue(0, 0, 1, 7,  22'd9,       0, "R6 dec no data");
        issue(1, 0, 0, 7,  22'd9,       1, "R7 nop with data");
        issue(1, 0, 0, 7,  22'd9,       0, "R7 R8 nop no data");
        issue(0, 0, 0, 3,  22'h2AAAAA,  1, "R7 empty with data");
        for (int k = 0; k < 16; k++) begin
            issue(k[2], !k[0], k[0], (k * 7) % 32, DW'(k * 262147 + 5), 1,
                  "R9 back-to-back");
        end
        issue(0, 0, 0, 0, '0, 0, "R8 idle tail");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule